// File: doc/BRIEF.md
# Supply Margin Rollback Controller

This block watches a stream of digitised supply-voltage samples and compares each one against a fixed window. A sample above the upper margin or below the lower margin counts as an emergency. An emergency passes through a programmable detection-delay pipeline, which models the sensor response time. It then starts a recovery sequence. The pipeline is held stalled for a fixed penalty window, and a one-cycle flush request is raised.

During recovery, a 32-entry register file is rewritten from its most recent checkpoint through four parallel write ports. This takes eight consecutive cycles.

The block keeps its own live copy of the register file by observing the core's write traffic. It copies that live image into a shadow checkpoint at a programmable period. Only after the whole penalty window has elapsed does the block raise an interrupt for software. The interrupt stays set until software acknowledges it. A status word holds the cycle stamp of the detection and whether the excursion was an overshoot or an undershoot. Violations that arrive while a recovery is already running are counted, and they do not start a new recovery.

Top module: `vem_ctrl`

## Requirements
- R1: A sample with `smp_valid` high is an emergency when `smp_mv` is greater than 1040 or less than 960. The values 1040 and 960 themselves are inside the window. A sample with `smp_valid` low never triggers anything, whatever its code.
- R2: With `det_delay` = d (0 to 15), a violating sample presented in cycle c raises `stall_req` in cycle c+d+1, and not earlier.
- R3: `stall_req` stays high for exactly 50 consecutive cycles per recovery. `flush_req` is high only in the first of those cycles.
- R4: In the first 8 stall cycles, all four bits of `rst_we` are high, and they are low otherwise. In stall cycle k (k = 0..7), port p (p = 0..3) writes register 4k+p. Port p uses bits [5p+4:5p] of `rst_addr` and bits [32p+31:32p] of `rst_data`. The data is the value held in the latest checkpoint.
- R5: A checkpoint copies the live register image every P cycles. P equals `ckpt_interval`, or 32 when that input is 0. The image holds every write committed on an earlier clock edge, so after P+1 cycles without writes the checkpoint matches the live image.
- R6: A violation detected while a stall is in progress adds one to `ovf_cnt`, which saturates at 15. It neither restarts nor extends the stall.
- R7: `irq` rises in the first cycle after the stall ends and never earlier. It then stays high until `sw_clear` is pulsed.
- R8: No checkpoint is taken during a stall, in the cycle of a detection, or in the cycle after it. A write made on the edge just before a detection is therefore lost. Writes presented while `stall_req` is high are ignored, and the live image becomes the restored image.
- R9: `stat_dir` is 1 for an overshoot and 0 for an undershoot. The difference between the `stat_ts` values of two recoveries equals the number of cycles between their detections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_mv | input | 12 | Supply sample, unsigned millivolts |
| det_delay | input | 4 | Detection latency in cycles |
| ckpt_interval | input | 8 | Checkpoint period; 0 selects 32 |
| rf_we | input | 1 | Live register write enable |
| rf_waddr | input | 5 | Live register write index |
| rf_wdata | input | 32 | Live register write data |
| sw_clear | input | 1 | Software acknowledge, clears the interrupt |
| rst_we | output | 4 | Restore write enables, one per port |
| rst_addr | output | 20 | Restore register indices, 5 bits per port |
| rst_data | output | 128 | Restore data, 32 bits per port |
| stall_req | output | 1 | Pipeline stall for the penalty window |
| flush_req | output | 1 | One-cycle flush at the start of recovery |
| irq | output | 1 | Recovery-complete interrupt |
| stat_ts | output | 32 | Cycle stamp of the last accepted detection |
| stat_dir | output | 1 | Direction of the last accepted violation |
| ovf_cnt | output | 4 | Saturating count of violations seen while stalled |

## Verification
Samples exactly on 960 and 1040, samples one code outside them, and out-of-window codes with `smp_valid` low separate an inclusive compare from an exclusive one and show that the qualifier is honoured. Random register traffic, random detection delays, random overshoot or undershoot magnitudes and several checkpoint periods show whether the restore ports replay the right register with the right data at the right delay. A write followed at once by a violation, and writes issued during a stall, show whether the checkpoint and the live image are protected from lost work. Violations held high across many cycles show whether the stall restarts and whether the overflow counter saturates.

// File: rtl/vem_pkg.sv
package vem_pkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_RECOVER = 1'b1
  } rec_state_e;

  // Window check: strictly outside [lo, hi] is a violation.
  function automatic logic outside_window(input logic [15:0] v,
                                          input logic [15:0] hi,
                                          input logic [15:0] lo);
    return (v > hi) || (v < lo);
  endfunction

  function automatic logic is_overshoot(input logic [15:0] v,
                                        input logic [15:0] hi);
    return v > hi;
  endfunction

  // A zero setting selects the default period.
  function automatic logic [15:0] eff_period(input logic [15:0] setting,
                                             input logic [15:0] dflt);
    return (setting == 16'd0) ? dflt : setting;
  endfunction

  // Register index written by one port during one restore beat.
  function automatic int unsigned restore_index(input int unsigned beat,
                                                input int unsigned port,
                                                input int unsigned ports);
    return beat * ports + port;
  endfunction

endpackage

// File: rtl/vem_detect.sv
module vem_detect #(
  parameter int SAMPLE_W = 12,
  parameter int DLY_W    = 4,
  parameter int HI_MV    = 1040,
  parameter int LO_MV    = 960,
  localparam int TAPS    = (1 << DLY_W) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_mv,
  input  logic [DLY_W-1:0]    dly,
  output logic                det_evt,
  output logic                det_dir
);

  logic            raw_vio;
  logic            raw_dir;
  logic [TAPS-1:0] vio_pipe;
  logic [TAPS-1:0] dir_pipe;
  logic [DLY_W-1:0] tap;

  assign raw_vio = smp_valid &&
                   vem_pkg::outside_window(16'(smp_mv), 16'(HI_MV), 16'(LO_MV));
  assign raw_dir = vem_pkg::is_overshoot(16'(smp_mv), 16'(HI_MV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vio_pipe <= '0;
      dir_pipe <= '0;
    end else begin
      vio_pipe <= {vio_pipe[TAPS-2:0], raw_vio};
      dir_pipe <= {dir_pipe[TAPS-2:0], raw_dir};
    end
  end

  assign tap = dly - 1'b1;

  always_comb begin
    if (dly == '0) begin
      det_evt = raw_vio;
      det_dir = raw_dir;
    end else begin
      det_evt = vio_pipe[tap];
      det_dir = dir_pipe[tap];
    end
  end

endmodule

// File: rtl/vem_seq.sv
module vem_seq #(
  parameter int PENALTY    = 50,
  parameter int BEATS      = 8,
  parameter int IVL_W      = 8,
  parameter int DEF_PERIOD = 32,
  parameter int TS_W       = 32,
  parameter int OVF_W      = 4,
  localparam int PW        = $clog2(PENALTY),
  localparam int BW        = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_evt,
  input  logic             det_dir,
  input  logic [IVL_W-1:0] ckpt_interval,
  input  logic             sw_clear,
  output logic             busy,
  output logic             accept,
  output logic             beat_valid,
  output logic [BW-1:0]    beat,
  output logic             flush,
  output logic             take_ckpt,
  output logic             irq,
  output logic [TS_W-1:0]  stat_ts,
  output logic             stat_dir,
  output logic [OVF_W-1:0] ovf_cnt
);

  vem_pkg::rec_state_e state_q;
  logic [PW-1:0]       pen_q;
  logic                finish;
  logic [TS_W-1:0]     cyc_q;
  logic [IVL_W-1:0]    ivl_cnt_q;
  logic [IVL_W-1:0]    period;
  logic                tick;
  logic                det_q;

  assign busy       = (state_q == vem_pkg::ST_RECOVER);
  assign accept     = det_evt && !busy;
  assign finish     = busy && (pen_q == PW'(PENALTY - 1));
  assign beat_valid = busy && (pen_q < PW'(BEATS));
  assign beat       = BW'(pen_q);
  assign flush      = busy && (pen_q == '0);

  assign period    = IVL_W'(vem_pkg::eff_period(16'(ckpt_interval), 16'(DEF_PERIOD)));
  assign tick      = (ivl_cnt_q >= period - 1'b1);
  assign take_ckpt = tick && !busy && !det_evt && !det_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= vem_pkg::ST_IDLE;
      pen_q   <= '0;
    end else if (accept) begin
      state_q <= vem_pkg::ST_RECOVER;
      pen_q   <= '0;
    end else if (finish) begin
      state_q <= vem_pkg::ST_IDLE;
      pen_q   <= '0;
    end else if (busy) begin
      pen_q   <= pen_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q     <= '0;
      ivl_cnt_q <= '0;
      det_q     <= 1'b0;
    end else begin
      cyc_q     <= cyc_q + 1'b1;
      ivl_cnt_q <= tick ? '0 : ivl_cnt_q + 1'b1;
      det_q     <= det_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      stat_ts  <= '0;
      stat_dir <= 1'b0;
      ovf_cnt  <= '0;
    end else begin
      if (finish)        irq <= 1'b1;
      else if (sw_clear) irq <= 1'b0;
      if (accept) begin
        stat_ts  <= cyc_q;
        stat_dir <= det_dir;
      end
      if (det_evt && busy && (ovf_cnt != '1)) ovf_cnt <= ovf_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/vem_ckpt_store.sv
module vem_ckpt_store #(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  parameter int PORTS  = 4,
  localparam int AW    = $clog2(NREGS),
  localparam int BEATS = NREGS / PORTS,
  localparam int BW    = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    take_ckpt,
  input  logic                    live_reload,
  input  logic                    beat_valid,
  input  logic [BW-1:0]           beat,
  output logic [PORTS-1:0]        rst_we,
  output logic [PORTS*AW-1:0]     rst_addr,
  output logic [PORTS*DATA_W-1:0] rst_data
);

  logic [DATA_W-1:0] live_q   [NREGS];
  logic [DATA_W-1:0] shadow_q [NREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        live_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      if (live_reload) begin
        for (int i = 0; i < NREGS; i++) live_q[i] <= shadow_q[i];
      end else if (wr_en) begin
        live_q[wr_addr] <= wr_data;
      end
      if (take_ckpt) begin
        for (int i = 0; i < NREGS; i++) shadow_q[i] <= live_q[i];
      end
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [AW-1:0] idx;
    assign idx = AW'(vem_pkg::restore_index(32'(beat), 32'(p), 32'(PORTS)));
    assign rst_we[p]                   = beat_valid;
    assign rst_addr[p*AW +: AW]        = idx;
    assign rst_data[p*DATA_W +: DATA_W] = shadow_q[idx];
  end

endmodule

// File: rtl/vem_ctrl.sv
module vem_ctrl #(
  parameter int SAMPLE_W   = 12,
  parameter int HI_MV      = 1040,
  parameter int LO_MV      = 960,
  parameter int DLY_W      = 4,
  parameter int NREGS      = 32,
  parameter int DATA_W     = 32,
  parameter int PORTS      = 4,
  parameter int PENALTY    = 50,
  parameter int IVL_W      = 8,
  parameter int DEF_PERIOD = 32,
  parameter int TS_W       = 32,
  parameter int OVF_W      = 4,
  localparam int AW        = $clog2(NREGS),
  localparam int BEATS     = NREGS / PORTS,
  localparam int BW        = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic [SAMPLE_W-1:0]     smp_mv,
  input  logic [DLY_W-1:0]        det_delay,
  input  logic [IVL_W-1:0]        ckpt_interval,
  input  logic                    rf_we,
  input  logic [AW-1:0]           rf_waddr,
  input  logic [DATA_W-1:0]       rf_wdata,
  input  logic                    sw_clear,
  output logic [PORTS-1:0]        rst_we,
  output logic [PORTS*AW-1:0]     rst_addr,
  output logic [PORTS*DATA_W-1:0] rst_data,
  output logic                    stall_req,
  output logic                    flush_req,
  output logic                    irq,
  output logic [TS_W-1:0]         stat_ts,
  output logic                    stat_dir,
  output logic [OVF_W-1:0]        ovf_cnt
);

  // Named internal events, observed by the bound checker.
  logic          det_evt;
  logic          det_dir;
  logic          accept_evt;
  logic          take_ckpt;
  logic          busy;
  logic          beat_valid;
  logic [BW-1:0] beat;

  vem_detect #(
    .SAMPLE_W(SAMPLE_W), .DLY_W(DLY_W), .HI_MV(HI_MV), .LO_MV(LO_MV)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .dly(det_delay), .det_evt(det_evt), .det_dir(det_dir)
  );

  vem_seq #(
    .PENALTY(PENALTY), .BEATS(BEATS), .IVL_W(IVL_W), .DEF_PERIOD(DEF_PERIOD),
    .TS_W(TS_W), .OVF_W(OVF_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .det_evt(det_evt), .det_dir(det_dir),
    .ckpt_interval(ckpt_interval), .sw_clear(sw_clear), .busy(busy),
    .accept(accept_evt), .beat_valid(beat_valid), .beat(beat),
    .flush(flush_req), .take_ckpt(take_ckpt), .irq(irq),
    .stat_ts(stat_ts), .stat_dir(stat_dir), .ovf_cnt(ovf_cnt)
  );

  vem_ckpt_store #(
    .NREGS(NREGS), .DATA_W(DATA_W), .PORTS(PORTS)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(rf_we && !busy), .wr_addr(rf_waddr),
    .wr_data(rf_wdata), .take_ckpt(take_ckpt), .live_reload(accept_evt),
    .beat_valid(beat_valid), .beat(beat), .rst_we(rst_we),
    .rst_addr(rst_addr), .rst_data(rst_data)
  );

  assign stall_req = busy;

endmodule

// File: rtl/vem_ctrl_chk.sv
module vem_ctrl_chk #(
  parameter int PENALTY = 50,
  parameter int PORTS   = 4,
  parameter int OVF_W   = 4,
  localparam int RW     = $clog2(PENALTY + 2) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_req,
  input logic             flush_req,
  input logic             irq,
  input logic [PORTS-1:0] rst_we,
  input logic [OVF_W-1:0] ovf_cnt,
  input logic             take_ckpt,
  input logic             det_evt
);

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_len <= '0;
    else if (stall_req) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  // R3
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_req) |-> (run_len == RW'(PENALTY)));

  // R3
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  // R4
  restore_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_we) |-> stall_req);

  // R4
  ports_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_we == '0) || (rst_we == '1));

  // R6
  ovf_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_cnt >= $past(ovf_cnt));

  // R7
  irq_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(stall_req));

  // R8
  no_ckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ckpt |-> (!stall_req && !det_evt));

endmodule

bind vem_ctrl vem_ctrl_chk #(
  .PENALTY(PENALTY), .PORTS(PORTS), .OVF_W(OVF_W)
) u_vem_chk (
  .clk(clk), .rst_n(rst_n), .stall_req(stall_req), .flush_req(flush_req),
  .irq(irq), .rst_we(rst_we), .ovf_cnt(ovf_cnt), .take_ckpt(take_ckpt),
  .det_evt(det_evt)
);

// File: tb/vem_ctrl_bench.sv
module vem_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_valid = 1'b0;
  logic [11:0]  smp_mv = 12'd1000;
  logic [3:0]   det_delay = '0;
  logic [7:0]   ckpt_interval = '0;
  logic         rf_we = 1'b0;
  logic [4:0]   rf_waddr = '0;
  logic [31:0]  rf_wdata = '0;
  logic         sw_clear = 1'b0;
  logic [3:0]   rst_we;
  logic [19:0]  rst_addr;
  logic [127:0] rst_data;
  logic         stall_req, flush_req, irq, stat_dir;
  logic [31:0]  stat_ts;
  logic [3:0]   ovf_cnt;

  vem_ctrl u_vem_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .det_delay(det_delay), .ckpt_interval(ckpt_interval), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .sw_clear(sw_clear),
    .rst_we(rst_we), .rst_addr(rst_addr), .rst_data(rst_data),
    .stall_req(stall_req), .flush_req(flush_req), .irq(irq),
    .stat_ts(stat_ts), .stat_dir(stat_dir), .ovf_cnt(ovf_cnt)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int          n_chk = 0;
  int          n_bad = 0;
  longint      ncyc = 0;
  logic [31:0] m_rf [32];
  logic [31:0] m_ck [32];
  int          ovf_exp = 0;

  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bper(input logic [7:0] iv);
    return (iv == 8'd0) ? 32 : int'(iv);
  endfunction

  function automatic int sat_add(input int a, input int b);
    return (a + b > 15) ? 15 : a + b;
  endfunction

  // R5: quiet for longer than one period, so the checkpoint equals the live image
  task automatic settle();
    repeat (bper(ckpt_interval) + 3) @(negedge clk);
    for (int i = 0; i < 32; i++) m_ck[i] = m_rf[i];
  endtask

  task automatic rand_writes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rf_we    = 1'b1;
      rf_waddr = 5'($urandom % 32);
      rf_wdata = $urandom;
      m_rf[rf_waddr] = rf_wdata;
    end
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  // Drives a violating sample held for 'hold' cycles, then checks the whole recovery.
  task automatic emergency(input int d, input logic [11:0] code, input bit exp_dir,
                           input int hold, input bit pre_wait, input bit wr_stall,
                           output longint stamp);
    bit ok;
    if (pre_wait) @(negedge clk);
    det_delay = 4'(d);
    smp_valid = 1'b1;
    smp_mv    = code;
    stamp     = ncyc + d;
    for (int k = 1; k <= d + 51; k++) begin
      @(negedge clk);
      if (k == hold) smp_valid = 1'b0;
      if (wr_stall && k == d + 10) begin
        rf_we = 1'b1; rf_waddr = 5'($urandom % 32); rf_wdata = $urandom;
      end
      if (wr_stall && k == d + 20) rf_we = 1'b0;
      if (d > 0 && k == d) check(stall_req == 1'b0, "R2", "stall early", stall_req, 0);
      if (k == d + 1) begin
        check(stall_req == 1'b1, "R2", "stall rise", stall_req, 1);
        check(flush_req == 1'b1, "R3", "flush first", flush_req, 1);
      end
      if (k == d + 2) check(flush_req == 1'b0, "R3", "flush one cycle", flush_req, 0);
      if (k >= d + 1 && k <= d + 8) begin
        ok = (rst_we == 4'hf);
        for (int p = 0; p < 4; p++) begin
          int r;
          r = 4 * (k - d - 1) + p;
          if (rst_addr[p*5 +: 5] != 5'(r)) ok = 0;
          if (rst_data[p*32 +: 32] != m_ck[r]) ok = 0;
        end
        check(ok, "R4", "restore beat", {rst_we, rst_addr}, {4'hf, 20'(k - d - 1)});
      end
      if (k == d + 9) check(rst_we == 4'h0, "R4", "restore end", rst_we, 0);
      if (k == d + 50) begin
        check(stall_req == 1'b1, "R3", "stall last", stall_req, 1);
        check(irq == 1'b0, "R7", "irq early", irq, 0);
      end
      if (k == d + 51) begin
        check(stall_req == 1'b0, "R3", "stall end", stall_req, 0);
        check(irq == 1'b1, "R7", "irq after", irq, 1);
        check(stat_dir == exp_dir, "R9", "direction", stat_dir, exp_dir);
      end
    end
    ovf_exp = sat_add(ovf_exp, hold - 1);
    check(ovf_cnt == 4'(ovf_exp), "R6", "overflow count", ovf_cnt, ovf_exp);
    for (int i = 0; i < 32; i++) m_rf[i] = m_ck[i];
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R7", "irq holds", irq, 1);
    sw_clear = 1'b1;
    @(negedge clk);
    sw_clear = 1'b0;
    check(irq == 1'b0, "R7", "irq cleared", irq, 0);
  endtask

  task automatic no_event(input logic v, input logic [11:0] code);
    bit seen;
    seen = 0;
    @(negedge clk);
    det_delay = 4'd0; smp_valid = v; smp_mv = code;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (20) begin
      if (stall_req) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R1", "no emergency", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R3 watchdog actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint s1, s2, s3;
    logic [31:0] ts1;
    bit over;
    logic [11:0] code;
    void'($urandom(32'd7));
    for (int i = 0; i < 32; i++) begin m_rf[i] = '0; m_ck[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(stall_req == 0 && irq == 0 && flush_req == 0, "R3", "reset outputs",
          {stall_req, irq, flush_req}, 0);
    check(ovf_cnt == 0 && rst_we == 0, "R6", "reset counters", {ovf_cnt, rst_we}, 0);

    // R1 boundaries and qualifier
    no_event(1'b1, 12'd1040);
    no_event(1'b1, 12'd960);
    no_event(1'b0, 12'd3000);
    no_event(1'b0, 12'd100);
    rand_writes(12);
    settle();
    emergency(0, 12'd1041, 1'b1, 1, 1'b1, 1'b0, s1);   // R1 just above
    ts1 = stat_ts;
    settle();
    emergency(3, 12'd959, 1'b0, 1, 1'b1, 1'b0, s2);    // R1 just below
    check(stat_ts - ts1 == 32'(s2 - s1), "R9", "stamp distance", stat_ts - ts1, s2 - s1);

    // R8: write on the edge just before a detection is lost
    rand_writes(4);
    settle();
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 5'd0; rf_wdata = ~m_ck[0]; m_rf[0] = ~m_ck[0];
    @(negedge clk);
    rf_we = 1'b0;
    emergency(0, 12'd1500, 1'b1, 1, 1'b0, 1'b0, s3);

    // R8: writes during a stall are ignored, the next recovery replays the old image
    settle();
    emergency(5, 12'd200, 1'b0, 1, 1'b1, 1'b1, s3);
    settle();
    emergency(1, 12'd1100, 1'b1, 1, 1'b1, 1'b0, s3);

    // R6: extra violations during the stall do not restart it
    settle();
    emergency(2, 12'd900, 1'b0, 3, 1'b1, 1'b0, s3);

    // R5 and R2: random traffic, periods, delays and magnitudes
    for (int it = 0; it < 16; it++) begin
      case ($urandom % 4)
        0: ckpt_interval = 8'd0;
        1: ckpt_interval = 8'd5;
        2: ckpt_interval = 8'd12;
        default: ckpt_interval = 8'd40;
      endcase
      rand_writes(1 + int'($urandom % 10));
      settle();
      over = 1'($urandom % 2);
      code = over ? 12'(1041 + $urandom % 500) : 12'($urandom % 960);
      emergency(int'($urandom % 16), code, over, 1, 1'b1, 1'b0, s3);
    end

    // R6: a violation held for 20 cycles saturates the counter
    settle();
    emergency(0, 12'd4000, 1'b1, 20, 1'b1, 1'b0, s3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule